// File: doc/BRIEF.md
# Two-Wire Slave Register File

This block is a slave on a two-wire (I2C-compatible) serial bus. It lets a bus master read and write a small bank of byte-wide registers, and other logic on the chip reaches the same registers through a plain local port. The system clock oversamples both bus lines. Each line passes through a synchronizer chain, and the block then detects clock edges and the start and stop conditions. A byte engine then decodes the device address, loads an internal pointer, writes data bytes and streams read data.

The bus line is driven open-drain. The block only ever pulls SDA low, by raising an output enable, and the pad is assumed to drive zero whenever that enable is set. The pointer advances after every byte that is written and after every read byte the master acknowledges. Any stop condition returns the pointer to zero. A master can therefore poll register zero with bare read transfers. Clock stretching, 10-bit addressing, general call and multi-master arbitration are not handled.

Top module: `i2cs_regfile_top`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start or stop that arrives in the middle of a byte abandons that byte, so a partial data byte is never written, and a fresh address phase follows a start.
- R2: After a start, the first byte is a 7-bit address sent MSB first, followed by a direction bit (0 = master writes, 1 = master reads). When the address equals DEV_ADDR (default 0x48, so bytes 0x90 and 0x91), the block pulls SDA low during the ninth clock. For any other address it leaves SDA released until the next start, and no register changes.
- R3: In a write transfer, the byte after the address byte loads the pointer and is acknowledged. Each later byte is stored in the register the pointer selects, is acknowledged, and advances the pointer by one.
- R4: In a read transfer, the register at the pointer is sent MSB first. When the master acknowledges (SDA low in the ninth clock), the pointer advances and the next register is sent. The pointer value itself is never what is returned.
- R5: When the master does not acknowledge a read byte, the block goes idle and leaves the pointer unchanged. A repeated-start read that follows returns the same register again.
- R6: Every stop condition, whether it ends a write or a read, sets the pointer to 0x00. A read transfer that follows without a pointer write starts at register 0x00.
- R7: Registers exist at 0x00 to NUM_REGS-1 (default 0x17). A data byte written at a higher pointer is acknowledged but stored nowhere, and a read at a higher pointer returns 0x00.
- R8: All registers reset to 0x00. The local port writes register loc_addr_i on a clock edge when loc_we_i is high, and loc_rdata_o shows register loc_addr_i combinationally. Bytes written over the bus appear on the local port, and bytes written locally appear on bus reads.
- R9: The output enable is low after reset and only becomes active while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Pull SDA low while high |
| loc_addr_i | input | AW (8) | Local port register address |
| loc_we_i | input | 1 | Local port write strobe |
| loc_wdata_i | input | 8 | Local port write data |
| loc_rdata_o | output | 8 | Local port read data for loc_addr_i |

## Verification
The bench drives the bus as a master with a wired-AND data line. It mixes constrained-random write bursts, pointer-then-repeated-start reads, bare reads and local writes against a register model. Write bursts that run across the top register separate acknowledged-but-dropped bytes from stored ones. A NACK followed by a repeated-start read tells a held pointer apart from an advanced one. A bare read after a stop shows whether the pointer was cleared. A foreign address, and a data byte cut short by a repeated start, both check that nothing is written.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_PTR,
      ST_PTR_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RACK
   } i2cs_state_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
   } bus_evt_t;

endpackage

// File: rtl/i2cs_line_mon.sv
module i2cs_line_mon
   import i2cs_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_i,
   input  logic     sda_i,
   output bus_evt_t evt,
   output logic     scl_lvl,
   output logic     sda_lvl
);

   logic [SYNC_STAGES-1:0] scl_ff;
   logic [SYNC_STAGES-1:0] sda_ff;
   logic                   scl_d;
   logic                   sda_d;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff[0] <= 1'b1;
               sda_ff[0] <= 1'b1;
            end else begin
               scl_ff[0] <= scl_i;
               sda_ff[0] <= sda_i;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff[s] <= 1'b1;
               sda_ff[s] <= 1'b1;
            end else begin
               scl_ff[s] <= scl_ff[s-1];
               sda_ff[s] <= sda_ff[s-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_lvl;
         sda_d <= sda_lvl;
      end
   end

   assign scl_lvl   = scl_ff[SYNC_STAGES-1];
   assign sda_lvl   = sda_ff[SYNC_STAGES-1];
   assign evt.start = scl_lvl & scl_d & sda_d & ~sda_lvl;
   assign evt.stop  = scl_lvl & scl_d & ~sda_d & sda_lvl;
   assign evt.rise  = scl_lvl & ~scl_d;
   assign evt.fall  = ~scl_lvl & scl_d;

   // R1: at most one bus event per system clock
   a_r1_single_event: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({evt.start, evt.stop, evt.rise, evt.fall}));

endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs #(
   parameter int         NUM_REGS = 24,
   parameter int         AW       = 8,
   parameter logic [7:0] OOB_VAL  = 8'h00
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [7:0]    bus_wdata,
   input  logic [AW-1:0] bus_raddr,
   output logic [7:0]    bus_rdata,
   input  logic          loc_we,
   input  logic [AW-1:0] loc_addr,
   input  logic [7:0]    loc_wdata,
   output logic [7:0]    loc_rdata
);

   localparam logic [AW:0] LIMIT = (AW+1)'(NUM_REGS);

   logic [NUM_REGS*8-1:0] flat;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= 8'h00;
         else if (bus_we && bus_addr == AW'(i))
            q <= bus_wdata;
         else if (loc_we && loc_addr == AW'(i))
            q <= loc_wdata;
      end
      assign flat[i*8 +: 8] = q;
   end

   function automatic logic [7:0] pick(input logic [AW-1:0] a, input logic [NUM_REGS*8-1:0] v);
      logic [7:0] d;
      d = OOB_VAL;
      for (int i = 0; i < NUM_REGS; i++)
         if (a == AW'(i)) d = v[i*8 +: 8];
      return d;
   endfunction

   assign bus_rdata = pick(bus_raddr, flat);
   assign loc_rdata = pick(loc_addr, flat);

   // R7: the engine never presents an out-of-range bus write
   a_r7_bus_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we |-> ({1'b0, bus_addr} < LIMIT));

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
   import i2cs_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h48,
   parameter int         NUM_REGS = 24,
   parameter int         AW       = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  bus_evt_t      evt,
   input  logic          scl_lvl,
   input  logic          sda_lvl,
   output logic          sda_oe,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [7:0]    wr_data,
   output logic [AW-1:0] rd_addr,
   input  logic [7:0]    rd_data
);

   localparam logic [AW:0] LIMIT = (AW+1)'(NUM_REGS);

   i2cs_state_e   state;
   logic [3:0]    bitcnt;
   logic [7:0]    shreg;
   logic          rw;
   logic          mack;
   logic [AW-1:0] ptr;
   logic          byte_done;

   assign byte_done = evt.fall && (bitcnt == 4'd8);
   assign wr_en     = (state == ST_WDATA) && byte_done && ({1'b0, ptr} < LIMIT);
   assign wr_addr   = ptr;
   assign wr_data   = shreg;
   assign rd_addr   = (state == ST_RACK) ? ptr + AW'(1) : ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         bitcnt <= '0;
         shreg  <= '0;
         rw     <= 1'b0;
         mack   <= 1'b0;
         ptr    <= '0;
         sda_oe <= 1'b0;
      end else if (evt.stop) begin
         state  <= ST_IDLE;
         bitcnt <= '0;
         ptr    <= '0;
         sda_oe <= 1'b0;
      end else if (evt.start) begin
         state  <= ST_ADDR;
         bitcnt <= '0;
         sda_oe <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: ;
            ST_ADDR, ST_PTR, ST_WDATA: begin
               if (evt.rise) begin
                  shreg  <= {shreg[6:0], sda_lvl};
                  bitcnt <= bitcnt + 4'd1;
               end else if (byte_done) begin
                  if (state == ST_ADDR) begin
                     if (shreg[7:1] == DEV_ADDR) begin
                        rw     <= shreg[0];
                        sda_oe <= 1'b1;
                        state  <= ST_ADDR_ACK;
                     end else begin
                        state  <= ST_IDLE;
                     end
                  end else if (state == ST_PTR) begin
                     ptr    <= shreg[AW-1:0];
                     sda_oe <= 1'b1;
                     state  <= ST_PTR_ACK;
                  end else begin
                     ptr    <= ptr + AW'(1);
                     sda_oe <= 1'b1;
                     state  <= ST_WDATA_ACK;
                  end
               end
            end
            ST_ADDR_ACK: begin
               if (evt.fall) begin
                  bitcnt <= '0;
                  if (rw) begin
                     shreg  <= rd_data;
                     sda_oe <= ~rd_data[7];
                     state  <= ST_RDATA;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= ST_PTR;
                  end
               end
            end
            ST_PTR_ACK, ST_WDATA_ACK: begin
               if (evt.fall) begin
                  bitcnt <= '0;
                  sda_oe <= 1'b0;
                  state  <= ST_WDATA;
               end
            end
            ST_RDATA: begin
               if (evt.rise) begin
                  bitcnt <= bitcnt + 4'd1;
               end else if (byte_done) begin
                  sda_oe <= 1'b0;
                  state  <= ST_RACK;
               end else if (evt.fall) begin
                  shreg  <= {shreg[6:0], 1'b0};
                  sda_oe <= ~shreg[6];
               end
            end
            ST_RACK: begin
               if (evt.rise) begin
                  mack <= ~sda_lvl;
               end else if (evt.fall) begin
                  if (mack) begin
                     ptr    <= ptr + AW'(1);
                     shreg  <= rd_data;
                     sda_oe <= ~rd_data[7];
                     bitcnt <= '0;
                     state  <= ST_RDATA;
                  end else begin
                     state  <= ST_IDLE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R9: the block starts pulling SDA only while SCL is low
   a_r9_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_lvl);

   // R2: an idle engine never holds the line
   a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);

   // R6: a stop leaves the pointer at zero
   a_r6_stop_clears_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      evt.stop |=> (ptr == '0));

   // R3: each stored byte advances the pointer
   a_r3_write_advances: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ptr == $past(ptr) + AW'(1)));

   // R4: a master ACK advances the pointer
   a_r4_ack_advances: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RACK && evt.fall && mack) |=> (ptr == $past(ptr) + AW'(1)));

   // R5: a master NACK keeps the pointer
   a_r5_nack_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RACK && evt.fall && !mack) |=> (ptr == $past(ptr)));

endmodule

// File: rtl/i2cs_regfile_top.sv
module i2cs_regfile_top #(
   parameter logic [6:0] DEV_ADDR    = 7'h48,
   parameter int         NUM_REGS    = 24,
   parameter int         AW          = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] OOB_VAL     = 8'h00
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   output logic          sda_oe_o,
   input  logic [AW-1:0] loc_addr_i,
   input  logic          loc_we_i,
   input  logic [7:0]    loc_wdata_i,
   output logic [7:0]    loc_rdata_o
);

   import i2cs_pkg::*;

   if (AW < 1 || AW > 8) begin : g_bad_aw
      $error("AW must lie in 1..8");
   end
   if (NUM_REGS < 1 || NUM_REGS > (1 << AW)) begin : g_bad_regs
      $error("NUM_REGS must fit the pointer width");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   bus_evt_t      evt;
   logic          scl_lvl;
   logic          sda_lvl;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [7:0]    wr_data;
   logic [AW-1:0] rd_addr;
   logic [7:0]    rd_data;

   i2cs_line_mon #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_mon (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (scl_i),
      .sda_i   (sda_i),
      .evt     (evt),
      .scl_lvl (scl_lvl),
      .sda_lvl (sda_lvl)
   );

   i2cs_engine #(
      .DEV_ADDR (DEV_ADDR),
      .NUM_REGS (NUM_REGS),
      .AW       (AW)
   ) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .scl_lvl (scl_lvl),
      .sda_lvl (sda_lvl),
      .sda_oe  (sda_oe_o),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   i2cs_regs #(
      .NUM_REGS (NUM_REGS),
      .AW       (AW),
      .OOB_VAL  (OOB_VAL)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (wr_en),
      .bus_addr  (wr_addr),
      .bus_wdata (wr_data),
      .bus_raddr (rd_addr),
      .bus_rdata (rd_data),
      .loc_we    (loc_we_i),
      .loc_addr  (loc_addr_i),
      .loc_wdata (loc_wdata_i),
      .loc_rdata (loc_rdata_o)
   );

endmodule

// File: tb/i2cs_regfile_top_tb.sv
module i2cs_regfile_top_tb;

   localparam logic [6:0] DEV = 7'h48;
   localparam int NREG = 24;
   localparam int Q    = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_oe;
   logic       sda_bus;
   logic [7:0] loc_addr = '0;
   logic       loc_we = 1'b0;
   logic [7:0] loc_wdata = '0;
   logic [7:0] loc_rdata;

   int n_tests = 0;
   int n_fail  = 0;
   int r9_bad  = 0;
   logic [7:0] model [NREG];
   int ptr_m = 0;
   logic [7:0] wbuf [8];

   assign sda_bus = sda_m & ~sda_oe;

   always #5 clk = ~clk;

   i2cs_regfile_top u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl),
      .sda_i       (sda_bus),
      .sda_oe_o    (sda_oe),
      .loc_addr_i  (loc_addr),
      .loc_we_i    (loc_we),
      .loc_wdata_i (loc_wdata),
      .loc_rdata_o (loc_rdata)
   );

   // R9 monitor: the enable must never start while SCL is high
   always @(posedge sda_oe) if (rst_n && scl) r9_bad++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_rd(input int a);
      return (a < NREG) ? model[a] : 8'h00;
   endfunction

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
      ptr_m = 0;
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; wq(); scl = 1'b1; wq(); b = sda_bus; wq(); scl = 1'b0; wq();
   endtask

   task automatic wr_byte(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      get_bit(b);
      ack = ~b;
   endtask

   task automatic rd_byte(output logic [7:0] d, input logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         d[i] = b;
      end
      put_bit(~ack);
   endtask

   task automatic loc_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      loc_addr = a; loc_wdata = d; loc_we = 1'b1;
      @(negedge clk);
      loc_we = 1'b0;
      if (a < NREG) model[a] = d;
   endtask

   task automatic loc_read(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      loc_addr = a;
      @(negedge clk);
      d = loc_rdata;
   endtask

   // R3 / R7: write n bytes of wbuf starting at pointer p, then stop
   task automatic wr_burst(input logic [7:0] p, input int n);
      logic a;
      i2c_start();
      wr_byte({DEV, 1'b0}, a); chk(a, "R2", a, 1);
      wr_byte(p, a);           chk(a, "R3", a, 1);
      ptr_m = p;
      for (int i = 0; i < n; i++) begin
         wr_byte(wbuf[i], a);
         chk(a, (ptr_m < NREG) ? "R3" : "R7", a, 1);
         if (ptr_m < NREG) model[ptr_m] = wbuf[i];
         ptr_m = (ptr_m + 1) & 255;
      end
      i2c_stop();
   endtask

   // R4: read n bytes from the current pointer, NACK on the last
   task automatic rd_burst(input int n, input bit do_stop, input string req);
      logic a;
      logic [7:0] v;
      i2c_start();
      wr_byte({DEV, 1'b1}, a); chk(a, "R2", a, 1);
      for (int i = 0; i < n; i++) begin
         rd_byte(v, i < n - 1);
         chk(v == exp_rd(ptr_m), req, v, exp_rd(ptr_m));
         if (i < n - 1) ptr_m = (ptr_m + 1) & 255;
      end
      if (do_stop) i2c_stop();
   endtask

   // set the pointer, then repeated-start read
   task automatic rd_from(input logic [7:0] p, input int n, input bit do_stop, input string req);
      logic a;
      i2c_start();
      wr_byte({DEV, 1'b0}, a); chk(a, "R2", a, 1);
      wr_byte(p, a);           chk(a, "R3", a, 1);
      ptr_m = p;
      rd_burst(n, do_stop, req);
   endtask

   initial begin
      logic [7:0] v;
      logic a;
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < NREG; i++) model[i] = 8'h00;
      repeat (4) @(negedge clk);
      chk(sda_oe == 1'b0, "R9", sda_oe, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R8: reset contents
      loc_read(8'h05, v); chk(v == 8'h00, "R8", v, 0);
      loc_read(8'h17, v); chk(v == 8'h00, "R8", v, 0);

      // R3 then R8: bus write visible at local port
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
      wr_burst(8'h02, 3);
      loc_read(8'h02, v); chk(v == 8'h11, "R8", v, 8'h11);
      loc_read(8'h04, v); chk(v == 8'h33, "R3", v, 8'h33);

      // R4: burst read across the written bytes
      rd_from(8'h02, 3, 1'b1, "R4");

      // R6: bare read after stop starts at register zero
      loc_write(8'h00, 8'hA5);
      loc_write(8'h01, 8'h5A);
      rd_burst(2, 1'b1, "R6");
      wbuf[0] = 8'h77;
      wr_burst(8'h09, 1);
      rd_burst(1, 1'b1, "R6");

      // R5: NACK holds the pointer for a repeated-start read
      rd_from(8'h03, 1, 1'b0, "R5");
      rd_burst(2, 1'b1, "R5");

      // R2: foreign address gets no ACK and writes nothing
      i2c_start();
      wr_byte({7'h21, 1'b0}, a); chk(!a, "R2", a, 0);
      wr_byte(8'h04, a);         chk(!a, "R2", a, 0);
      wr_byte(8'hEE, a);         chk(!a, "R2", a, 0);
      i2c_stop();
      loc_read(8'h04, v); chk(v == 8'h33, "R2", v, 8'h33);

      // R7: burst across the top, then read past it
      wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3; wbuf[3] = 8'hC4;
      wr_burst(8'h16, 4);
      loc_read(8'h17, v); chk(v == 8'hC2, "R7", v, 8'hC2);
      loc_read(8'h00, v); chk(v == 8'hA5, "R7", v, 8'hA5);
      rd_from(8'h17, 3, 1'b1, "R7");

      // R1: repeated start halfway through a data byte
      i2c_start();
      wr_byte({DEV, 1'b0}, a); chk(a, "R2", a, 1);
      wr_byte(8'h05, a);       chk(a, "R3", a, 1);
      put_bit(1'b1); put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
      ptr_m = 5;
      rd_burst(1, 1'b1, "R1");
      loc_read(8'h05, v); chk(v == model[5], "R1", v, model[5]);

      // constrained random mix
      for (int it = 0; it < 30; it++) begin
         int kind;
         int n;
         logic [7:0] p;
         kind = $urandom_range(0, 3);
         n = $urandom_range(1, 4);
         p = 8'($urandom_range(0, 29));
         case (kind)
            0: begin
               for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
               wr_burst(p, n);
            end
            1: rd_from(p, n, 1'b1, "R4");
            2: begin
               loc_write(8'($urandom_range(0, NREG - 1)), 8'($urandom));
               rd_from(p, n, 1'b1, "R8");
            end
            default: rd_burst(n, 1'b1, "R6");
         endcase
      end

      chk(r9_bad == 0, "R9", r9_bad, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule